// File: doc/BRIEF.md
# Three-Smallest Match Cost Tracker

This block keeps a ranked list of the three lowest match costs seen during a block-matching search, each with the offset tag of the candidate that produced it. A search engine presents one candidate per cycle as a 16-bit cost with its tag. The block compares the cost with all three stored entries in the same cycle. The borrow of each subtraction decides where the candidate goes. The candidate takes the first rank whose stored cost is strictly larger than it. Every entry from that rank down moves one place lower, and the entry that was last is dropped.

A synchronous clear starts a new search. It fills every slot with the all-ones cost and marks each slot empty. The ranked outputs can be read at any time. After the last candidate of a search they give the three best offsets, best first, for a following refinement step that searches around several winners.

Top module: `least3_tracker`

## Requirements
- R1: Among the filled slots, rank 0 holds the smallest cost, and no rank holds a larger cost than the rank after it.
- R2: A valid candidate whose cost is strictly below the rank 0 cost enters rank 0. Ranks 0 and 1 move to ranks 1 and 2, and the old rank 2 is dropped.
- R3: A valid candidate that is not below rank k-1 but is strictly below rank k enters rank k. Ranks below k move one place down and ranks above k keep their contents.
- R4: A candidate equal to a stored cost is placed after that entry and never ahead of it.
- R5: A valid candidate whose cost is equal to or above the last rank leaves every slot unchanged.
- R6: A clear on `clr` loads every slot with cost 0xFFFF, tag 0 and the empty flag on the next edge. This happens even when a candidate is valid in the same cycle, and the candidate is discarded.
- R7: Each offset tag stays with its cost and moves with it whenever that cost changes rank.
- R8: While `cand_vld` is low and `clr` is low, no slot changes, whatever values the cost and tag inputs carry.
- R9: An accepted candidate appears at the outputs after exactly one clock edge. A new candidate can be given every cycle.
- R10: The asynchronous active-low reset gives the same slot contents as a clear.
- R11: `rank_vld` bit k is 1 when rank k holds a candidate. Filled slots always form a prefix from rank 0. A candidate with cost 0xFFFF never fills an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear that starts a new search |
| cand_vld | input | 1 | Candidate present this cycle |
| cand_sad | input | 16 | Candidate match cost |
| cand_tag | input | 8 | Candidate offset tag |
| rank_vld | output | 3 | Per-rank filled flags, bit 0 = best |
| rank_sad | output | 3x16 | Ranked costs, element 0 = smallest |
| rank_tag | output | 3x8 | Offset tags matching `rank_sad` |

## Verification
Falling cost sequences always insert at rank 0, so they exercise the full shift chain and the drop of the last rank. Rising sequences and mid-range values show whether the middle and last ranks are selected correctly and whether the ranks above the insertion point hold. Runs of equal costs tell a strict comparison from a non-strict one, because only a strict one keeps the earlier tags in front. Streams with a new candidate every cycle, a clear at the same time as a candidate, the value 0xFFFF after a clear, and idle cycles with changing data confirm the timing, the clear priority, the empty-slot rule and the hold behaviour.

// File: rtl/least3_pkg.sv
package least3_pkg;

  // What a ranked slot does on the next edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } slot_act_e;

endpackage

// File: rtl/least3_cmp.sv
// Strict less-than taken from the borrow (sign) of an extended subtraction.
module least3_cmp #(
  parameter int SAD_W = 16
) (
  input  logic [SAD_W-1:0] cand_sad,
  input  logic [SAD_W-1:0] slot_sad,
  output logic             cand_lt
);

  localparam int EXT_W = SAD_W + 1;

  function automatic logic borrow_of(input logic [SAD_W-1:0] a,
                                     input logic [SAD_W-1:0] b);
    logic [EXT_W-1:0] diff;
    diff = {1'b0, a} - {1'b0, b};
    return diff[EXT_W-1];
  endfunction

  assign cand_lt = borrow_of(cand_sad, slot_sad);

endmodule

// File: rtl/least3_steer.sv
// Turns the thermometer of comparator signs into one action per slot.
module least3_steer
  import least3_pkg::*;
#(
  parameter int NRANK = 3
) (
  input  logic                  clr,
  input  logic                  cand_vld,
  input  logic [NRANK-1:0]      cand_lt,
  output slot_act_e [NRANK-1:0] slot_act,
  output logic [NRANK-1:0]      ins_onehot
);

  logic accept;
  assign accept = cand_vld & ~clr;

  for (genvar j = 0; j < NRANK; j++) begin : g_rank
    logic above_lt;
    if (j == 0) begin : g_head
      assign above_lt = 1'b0;
    end else begin : g_tail
      assign above_lt = cand_lt[j-1];
    end

    assign ins_onehot[j] = accept & cand_lt[j] & ~above_lt;

    always_comb begin
      if (clr)
        slot_act[j] = ACT_CLEAR;
      else if (!cand_vld)
        slot_act[j] = ACT_HOLD;
      else if (above_lt)
        slot_act[j] = ACT_SHIFT;
      else if (cand_lt[j])
        slot_act[j] = ACT_LOAD;
      else
        slot_act[j] = ACT_HOLD;
    end
  end

endmodule

// File: rtl/least3_slot.sv
// One ranked storage slot: cost, tag and filled flag.
module least3_slot
  import least3_pkg::*;
#(
  parameter int SAD_W = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_act_e        act,
  input  logic [SAD_W-1:0] cand_sad,
  input  logic [TAG_W-1:0] cand_tag,
  input  logic [SAD_W-1:0] up_sad,
  input  logic [TAG_W-1:0] up_tag,
  input  logic             up_vld,
  output logic [SAD_W-1:0] sad,
  output logic [TAG_W-1:0] tag,
  output logic             vld
);

  localparam logic [SAD_W-1:0] SAD_EMPTY = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sad <= SAD_EMPTY;
      tag <= '0;
      vld <= 1'b0;
    end else begin
      unique case (act)
        ACT_CLEAR: begin
          sad <= SAD_EMPTY;
          tag <= '0;
          vld <= 1'b0;
        end
        ACT_SHIFT: begin
          sad <= up_sad;
          tag <= up_tag;
          vld <= up_vld;
        end
        ACT_LOAD: begin
          sad <= cand_sad;
          tag <= cand_tag;
          vld <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/least3_tracker.sv
// Top: ranked three-smallest cost tracker with offset tags.
module least3_tracker
  import least3_pkg::*;
#(
  parameter int SAD_W = 16,
  parameter int TAG_W = 8,
  parameter int NRANK = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        cand_vld,
  input  logic [SAD_W-1:0]            cand_sad,
  input  logic [TAG_W-1:0]            cand_tag,
  output logic [NRANK-1:0]            rank_vld,
  output logic [NRANK-1:0][SAD_W-1:0] rank_sad,
  output logic [NRANK-1:0][TAG_W-1:0] rank_tag
);

  // Named internal events, visible to the bound checker
  logic [NRANK-1:0]      cand_lt;
  logic [NRANK-1:0]      ins_onehot;
  slot_act_e [NRANK-1:0] slot_act;

  for (genvar j = 0; j < NRANK; j++) begin : g_cmp
    least3_cmp #(.SAD_W(SAD_W)) u_cmp (
      .cand_sad (cand_sad),
      .slot_sad (rank_sad[j]),
      .cand_lt  (cand_lt[j])
    );
  end

  least3_steer #(.NRANK(NRANK)) u_steer (
    .clr        (clr),
    .cand_vld   (cand_vld),
    .cand_lt    (cand_lt),
    .slot_act   (slot_act),
    .ins_onehot (ins_onehot)
  );

  for (genvar j = 0; j < NRANK; j++) begin : g_slot
    logic [SAD_W-1:0] up_sad;
    logic [TAG_W-1:0] up_tag;
    logic             up_vld;

    if (j == 0) begin : g_head
      assign up_sad = cand_sad;
      assign up_tag = cand_tag;
      assign up_vld = 1'b1;
    end else begin : g_tail
      assign up_sad = rank_sad[j-1];
      assign up_tag = rank_tag[j-1];
      assign up_vld = rank_vld[j-1];
    end

    least3_slot #(.SAD_W(SAD_W), .TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (slot_act[j]),
      .cand_sad (cand_sad),
      .cand_tag (cand_tag),
      .up_sad   (up_sad),
      .up_tag   (up_tag),
      .up_vld   (up_vld),
      .sad      (rank_sad[j]),
      .tag      (rank_tag[j]),
      .vld      (rank_vld[j])
    );
  end

endmodule

// File: rtl/least3_tracker_chk.sv
module least3_tracker_chk #(
  parameter int SAD_W = 16,
  parameter int TAG_W = 8,
  parameter int NRANK = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clr,
  input logic                        cand_vld,
  input logic [SAD_W-1:0]            cand_sad,
  input logic [NRANK-1:0]            rank_vld,
  input logic [NRANK-1:0][SAD_W-1:0] rank_sad,
  input logic [NRANK-1:0][TAG_W-1:0] rank_tag,
  input logic [NRANK-1:0]            ins_onehot
);

  for (genvar j = 0; j + 1 < NRANK; j++) begin : g_pair
    AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      rank_vld[j+1] |-> (rank_sad[j] <= rank_sad[j+1])); // R1
    AST_FILL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      !rank_vld[j] |-> !rank_vld[j+1]); // R11
  end

  AST_HEAD_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && !clr && cand_sad < rank_sad[0]) |=>
      (rank_sad[0] == $past(cand_sad)) && (rank_sad[1] == $past(rank_sad[0]))); // R2

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ins_onehot)); // R3

  AST_NO_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_vld && !clr && cand_sad >= rank_sad[NRANK-1]) |=>
      $stable(rank_sad) && $stable(rank_tag)); // R5

  AST_CLEAR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rank_vld == '0) && (rank_sad == '1) && (rank_tag == '0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cand_vld && !clr) |=>
      $stable(rank_sad) && $stable(rank_tag) && $stable(rank_vld)); // R8

endmodule

bind least3_tracker least3_tracker_chk #(
  .SAD_W(SAD_W), .TAG_W(TAG_W), .NRANK(NRANK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .cand_vld   (cand_vld),
  .cand_sad   (cand_sad),
  .rank_vld   (rank_vld),
  .rank_sad   (rank_sad),
  .rank_tag   (rank_tag),
  .ins_onehot (ins_onehot)
);

// File: tb/sim_least3_tracker.sv
`timescale 1ns/1ps
module sim_least3_tracker;

  localparam int SW = 16;
  localparam int TW = 8;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic cand_vld = 1'b0;
  logic [SW-1:0] cand_sad = '0;
  logic [TW-1:0] cand_tag = '0;
  logic [NR-1:0]         rank_vld;
  logic [NR-1:0][SW-1:0] rank_sad;
  logic [NR-1:0][TW-1:0] rank_tag;

  int checks = 0;
  int errors = 0;

  logic [SW-1:0] exp_sad [NR];
  logic [TW-1:0] exp_tag [NR];
  logic          exp_vld [NR];

  always #2.5 clk = ~clk;

  least3_tracker #(.SAD_W(SW), .TAG_W(TW), .NRANK(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cand_vld(cand_vld),
    .cand_sad(cand_sad), .cand_tag(cand_tag),
    .rank_vld(rank_vld), .rank_sad(rank_sad), .rank_tag(rank_tag)
  );

  function automatic void model_clear();
    for (int i = 0; i < NR; i++) begin
      exp_sad[i] = 16'hFFFF; exp_tag[i] = '0; exp_vld[i] = 1'b0;
    end
  endfunction

  // Scan from the bottom for the first rank the candidate beats
  function automatic void model_insert(input logic [SW-1:0] s, input logic [TW-1:0] t);
    int pos = NR;
    for (int i = NR - 1; i >= 0; i--)
      if (s < exp_sad[i]) pos = i;
    if (pos < NR) begin
      for (int i = NR - 1; i > pos; i--) begin
        exp_sad[i] = exp_sad[i-1]; exp_tag[i] = exp_tag[i-1]; exp_vld[i] = exp_vld[i-1];
      end
      exp_sad[pos] = s; exp_tag[pos] = t; exp_vld[pos] = 1'b1;
    end
  endfunction

  task automatic check_all(input string req);
    checks++;
    for (int i = 0; i < NR; i++) begin
      if (rank_sad[i] !== exp_sad[i] || rank_tag[i] !== exp_tag[i] || rank_vld[i] !== exp_vld[i]) begin
        errors++;
        $display("FAIL %s rank%0d actual sad=%h tag=%h vld=%b expected sad=%h tag=%h vld=%b",
                 req, i, rank_sad[i], rank_tag[i], rank_vld[i], exp_sad[i], exp_tag[i], exp_vld[i]);
        break;
      end
    end
  endtask

  task automatic check_order();
    checks++;
    for (int i = 0; i + 1 < NR; i++)
      if (rank_vld[i+1] && rank_sad[i] > rank_sad[i+1]) begin
        errors++;
        $display("FAIL R1 rank%0d actual %h > %h expected nondecreasing", i, rank_sad[i], rank_sad[i+1]);
      end
  endtask

  // Entered at a falling edge; returns at the next one with outputs updated
  task automatic push(input logic [SW-1:0] s, input logic [TW-1:0] t);
    cand_vld = 1'b1; cand_sad = s; cand_tag = t;
    @(negedge clk);
    cand_vld = 1'b0;
    model_insert(s, t);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    model_clear();
    check_all("R10");
  endtask

  task automatic t_falling();
    do_clear();
    for (int k = 0; k < 5; k++) begin
      push(16'(50 - 10 * k), 8'(k + 1));
      check_all("R2");
    end
    check_all("R7");
  endtask

  task automatic t_middle();
    do_clear();
    push(16'd10, 8'hA0); push(16'd30, 8'hA1);
    push(16'd20, 8'hA2); check_all("R3");
    push(16'd15, 8'hA3); check_all("R3");
    push(16'd18, 8'hA4); check_all("R3");
    push(16'd12, 8'hA5); check_all("R7");
  endtask

  task automatic t_ties();
    do_clear();
    push(16'd20, 8'h01); push(16'd20, 8'h02); check_all("R4");
    push(16'd20, 8'h03); check_all("R4");
    push(16'd20, 8'h04); check_all("R5");
    push(16'd99, 8'h05); check_all("R5");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 4; k++) begin
      cand_vld = 1'b0; cand_sad = 16'(k); cand_tag = 8'(k + 8'h70);
      @(negedge clk);
    end
    check_all("R8");
  endtask

  task automatic t_clear_wins();
    cand_vld = 1'b1; cand_sad = 16'd1; cand_tag = 8'h55; clr = 1'b1;
    @(negedge clk);
    cand_vld = 1'b0; clr = 1'b0;
    model_clear();
    check_all("R6");
  endtask

  task automatic t_empty_sentinel();
    do_clear();
    push(16'hFFFF, 8'h11); check_all("R11");
    push(16'hFFFE, 8'h12); check_all("R11");
  endtask

  task automatic t_stream();
    logic [15:0] lfsr = 16'hACE1;
    do_clear();
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push({4'h0, lfsr[11:0]}, 8'(k));
      check_all("R9");
      check_order();
    end
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_falling();
    t_middle();
    t_idle();
    t_ties();
    t_clear_wins();
    t_empty_sentinel();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule